// File: doc/BRIEF.md
# Nonvolatile Memory Control Register

This block is the 8-bit control and status register that a CPU uses to run operations on an on-chip nonvolatile memory. Software picks the target space with two select bits: program flash, data EEPROM or configuration space. It arms writes with a write-enable bit and chooses row erase instead of write with an erase-enable bit. It then sets a start bit for either a one-cycle read or a self-timed write/erase. Hardware clears the start bits itself. The read strobe is refused for targets that cannot be read this way.

The register talks to a self-timed programming engine. The engine receives a one-cycle start pulse and a level that marks an erase. It answers with a one-cycle done pulse, or with an abort pulse when a reset cuts the operation short. An error flag records an aborted cycle or an improper start attempt. When the flag is raised, the select bits keep their values, so software can later find out which space the failed operation was aimed at. While an operation is in flight, the target and the erase choice are locked.

Top module: `nvm_ctl_reg`

## Requirements
- R1: The register layout is, from bit 7 down to bit 0: program-flash select (1 = flash, 0 = data EEPROM), configuration select, an unused bit that always reads 0, row-erase enable, error flag, write enable, write start, read start.
- R2: The write start and read start bits can only be set by a CPU write. A CPU write of 0 to either bit leaves it unchanged.
- R3: An accepted read start sets bit 0 and `rd_strobe` for exactly the one cycle after the write, then clears by itself.
- R4: A read start is ignored when the stored program-flash select or configuration select is 1.
- R5: A write start with write enable already 1 sets bit 1 and raises `op_start` for one cycle. Bit 1 stays 1 until `eng_done`, which clears bit 1 and the error flag.
- R6: A write start while write enable is 0 is ignored and sets the error flag.
- R7: If row-erase enable is 1 when an operation starts, `op_erase` is 1 for its whole duration. `eng_done` clears row-erase enable.
- R8: `eng_abort` during an operation clears write start and row-erase enable and sets the error flag. The select bits and write enable keep their values. Abort takes priority over a simultaneous done.
- R9: While `rst_n` is low, every bit reads 0 and no strobe is raised. Reset is released `SYNC_STAGES` clock edges after `rst_n` rises.
- R10: While an operation is in progress, CPU writes to the select bits and to row-erase enable are ignored.
- R11: When no hardware event is pending, the CPU may write the error flag and the write-enable bit to either value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Current register value |
| sel_prog | output | 1 | Target is program flash (else data EEPROM) |
| sel_cfg | output | 1 | Target is configuration space |
| rd_strobe | output | 1 | One-cycle read request to the array |
| op_start | output | 1 | One-cycle write/erase launch to the engine |
| op_erase | output | 1 | Current operation is a row erase |
| eng_done | input | 1 | Engine finished the operation (one cycle) |
| eng_abort | input | 1 | Operation cut short by a reset (one cycle) |

## Verification
The bench builds the register with `SYNC_STAGES` = 3, so the delay from reset release to the first usable write is longer than the default. The bench's engine model is given a latency of six cycles. That window is long enough to make locked writes during a busy cycle, and to inject an abort before done arrives, so the target lock and the error-flag retention can both be observed. Read blocking is exercised with each select bit set on its own.

// File: rtl/nvm_ctl_pkg.sv
package nvm_ctl_pkg;
  localparam int REG_W = 8;

  // Field order is the bit order software sees (MSB first).
  typedef struct packed {
    logic sel_prog;
    logic sel_cfg;
    logic unused;
    logic erase_en;
    logic err;
    logic wren;
    logic wr_go;
    logic rd_go;
  } nvm_ctl_t;
endpackage

// File: rtl/nvm_rst_sync.sv
module nvm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/nvm_ctl_decode.sv
module nvm_ctl_decode
  import nvm_ctl_pkg::*;
(
  input  logic     cpu_we,
  input  nvm_ctl_t wr_fields,
  input  nvm_ctl_t cur,
  output logic     tgt_we,
  output logic     go_ok,
  output logic     go_bad,
  output logic     rd_ok
);
  logic go_req;
  logic rd_req;

  always_comb begin
    go_req = cpu_we && wr_fields.wr_go && !cur.wr_go;
    rd_req = cpu_we && wr_fields.rd_go;
    tgt_we = cpu_we && !cur.wr_go;
    go_ok  = go_req && cur.wren;
    go_bad = go_req && !cur.wren;
    rd_ok  = rd_req && !cur.sel_prog && !cur.sel_cfg;
  end
endmodule

// File: rtl/nvm_ctl_state.sv
module nvm_ctl_state
  import nvm_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cpu_we,
  input  nvm_ctl_t wr_fields,
  input  logic     tgt_we,
  input  logic     go_ok,
  input  logic     go_bad,
  input  logic     rd_ok,
  input  logic     eng_done,
  input  logic     eng_abort,
  output nvm_ctl_t cur,
  output logic     start_q
);
  nvm_ctl_t nxt;
  logic     start_d;
  logic     upd_en;

  always_comb begin
    nxt        = cur;
    nxt.unused = 1'b0;
    nxt.rd_go  = rd_ok;
    if (cpu_we) begin
      nxt.wren = wr_fields.wren;
      nxt.err  = wr_fields.err;
    end
    if (tgt_we) begin
      nxt.sel_prog = wr_fields.sel_prog;
      nxt.sel_cfg  = wr_fields.sel_cfg;
      nxt.erase_en = wr_fields.erase_en;
    end
    if (go_ok)  nxt.wr_go = 1'b1;
    if (go_bad) nxt.err   = 1'b1;
    if (cur.wr_go && eng_abort) begin
      nxt.wr_go    = 1'b0;
      nxt.erase_en = 1'b0;
      nxt.err      = 1'b1;
    end else if (cur.wr_go && eng_done) begin
      nxt.wr_go    = 1'b0;
      nxt.erase_en = 1'b0;
      nxt.err      = 1'b0;
    end
    start_d = go_ok;
    upd_en  = cpu_we || cur.rd_go || start_q || (cur.wr_go && (eng_done || eng_abort));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur     <= '0;
      start_q <= 1'b0;
    end else if (upd_en) begin
      cur     <= nxt;
      start_q <= start_d;
    end
  end
endmodule

// File: rtl/nvm_ctl_reg.sv
module nvm_ctl_reg
  import nvm_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_we,
  input  logic [REG_W-1:0] cpu_wdata,
  output logic [REG_W-1:0] cpu_rdata,
  output logic             sel_prog,
  output logic             sel_cfg,
  output logic             rd_strobe,
  output logic             op_start,
  output logic             op_erase,
  input  logic             eng_done,
  input  logic             eng_abort
);
  logic     rst_int_n;
  nvm_ctl_t wr_fields;
  nvm_ctl_t cur;
  logic     tgt_we;
  logic     go_ok;
  logic     go_bad;
  logic     rd_ok;

  assign wr_fields = nvm_ctl_t'(cpu_wdata);

  nvm_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  nvm_ctl_decode i_decode (
    .cpu_we    (cpu_we),
    .wr_fields (wr_fields),
    .cur       (cur),
    .tgt_we    (tgt_we),
    .go_ok     (go_ok),
    .go_bad    (go_bad),
    .rd_ok     (rd_ok)
  );

  nvm_ctl_state i_state (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cpu_we    (cpu_we),
    .wr_fields (wr_fields),
    .tgt_we    (tgt_we),
    .go_ok     (go_ok),
    .go_bad    (go_bad),
    .rd_ok     (rd_ok),
    .eng_done  (eng_done),
    .eng_abort (eng_abort),
    .cur       (cur),
    .start_q   (op_start)
  );

  assign cpu_rdata = REG_W'(cur);
  assign sel_prog  = cur.sel_prog;
  assign sel_cfg   = cur.sel_cfg;
  assign rd_strobe = cur.rd_go;
  assign op_erase  = cur.wr_go && cur.erase_en;
endmodule

// File: rtl/nvm_ctl_chk.sv
module nvm_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_we,
  input logic [7:0] cpu_wdata,
  input logic [7:0] cpu_rdata,
  input logic       sel_prog,
  input logic       sel_cfg,
  input logic       rd_strobe,
  input logic       op_start,
  input logic       op_erase,
  input logic       eng_done,
  input logic       eng_abort
);
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !cpu_rdata[5]); // R1
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !(cpu_we && cpu_wdata[0]) |=> !rd_strobe); // R3
  AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    sel_prog || sel_cfg |=> !rd_strobe); // R4
  AST_START_NEEDS_WREN: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rdata[2] && !cpu_rdata[1] |=> !op_start); // R6
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[1] && eng_done && !eng_abort |=> !cpu_rdata[1] && !cpu_rdata[4] && !cpu_rdata[3]); // R5
  AST_ABORT_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[1] && eng_abort |=> cpu_rdata[3] && !cpu_rdata[1] && $stable({sel_prog, sel_cfg})); // R8
  AST_TARGET_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[1] |=> $stable({sel_prog, sel_cfg})); // R10
  AST_ERASE_IN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    op_erase |-> cpu_rdata[1] && cpu_rdata[4]); // R7
endmodule

bind nvm_ctl_reg nvm_ctl_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_we    (cpu_we),
  .cpu_wdata (cpu_wdata),
  .cpu_rdata (cpu_rdata),
  .sel_prog  (sel_prog),
  .sel_cfg   (sel_cfg),
  .rd_strobe (rd_strobe),
  .op_start  (op_start),
  .op_erase  (op_erase),
  .eng_done  (eng_done),
  .eng_abort (eng_abort)
);

// File: tb/test_nvm_ctl_reg.sv
`timescale 1ns/100ps
module test_nvm_ctl_reg;
  localparam int SYNC = 3;
  localparam int ENG_LAT = 6;
  localparam int NVEC = 12;
  // {write data, expected register value after the write}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h00_00, 16'h20_00, 16'h01_01, 16'h80_80, 16'h81_80, 16'h40_40,
    16'h41_40, 16'h00_00, 16'h02_08, 16'h00_00, 16'h04_04, 16'h14_14
  };
  localparam string VTAG [NVEC] = '{
    "R1", "R1", "R3", "R1", "R4", "R1", "R4", "R1", "R6", "R11", "R11", "R1"
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_we = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       sel_prog, sel_cfg, rd_strobe, op_start, op_erase;
  logic       eng_done;
  logic       eng_abort = 1'b0;
  int         eng_cnt;
  int         n_run = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  nvm_ctl_reg #(.SYNC_STAGES(SYNC)) i_nvm_ctl_reg (
    .clk, .rst_n, .cpu_we, .cpu_wdata, .cpu_rdata, .sel_prog, .sel_cfg,
    .rd_strobe, .op_start, .op_erase, .eng_done, .eng_abort
  );

  // Programming engine model: fixed latency, cancelled by an abort.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_cnt  <= 0;
      eng_done <= 1'b0;
    end else begin
      eng_done <= 1'b0;
      if (eng_abort)          eng_cnt <= 0;
      else if (op_start)      eng_cnt <= ENG_LAT;
      else if (eng_cnt != 0) begin
        eng_cnt <= eng_cnt - 1;
        if (eng_cnt == 1) eng_done <= 1'b1;
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1;
    cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
    cpu_wdata = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && cpu_rdata[1]; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9", cpu_rdata, 8'h00);
    check("R9", {rd_strobe, op_start, op_erase}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    cpu_we = 1'b1; cpu_wdata = 8'h04;   // write during synchroniser delay
    @(negedge clk);
    cpu_we = 1'b0; cpu_wdata = '0;
    check("R9", cpu_rdata, 8'h00);
    repeat (SYNC + 1) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      cpu_write(VEC[v][15:8]);
      check(VTAG[v], cpu_rdata, VEC[v][7:0]);
      @(negedge clk);
    end

    // R3: read strobe lasts one cycle
    cpu_write(8'h01);
    check("R3", {7'b0, rd_strobe}, 8'h01);
    @(negedge clk);
    check("R3", {7'b0, rd_strobe}, 8'h00);

    // R5 / R10 / R2: write cycle and target lock
    cpu_write(8'h04);
    cpu_write(8'h86);
    check("R5", cpu_rdata, 8'h86);
    check("R5", {op_start, op_erase}, 8'h02);
    @(negedge clk);
    check("R5", {7'b0, op_start}, 8'h00);
    cpu_write(8'h44);
    check("R10", cpu_rdata, 8'h86);
    cpu_write(8'h14);
    check("R2", cpu_rdata, 8'h86);
    wait_idle();
    check("R5", cpu_rdata, 8'h84);

    // R7: row erase
    cpu_write(8'h94);
    cpu_write(8'h96);
    check("R7", {op_start, op_erase}, 8'h03);
    wait_idle();
    check("R7", cpu_rdata, 8'h84);

    // R8: abort keeps selects
    cpu_write(8'h44);
    cpu_write(8'h46);
    @(negedge clk);
    eng_abort = 1'b1;
    @(negedge clk);
    eng_abort = 1'b0;
    check("R8", cpu_rdata, 8'h4C);

    // R5: successful completion clears the error flag
    cpu_write(8'h4E);
    check("R5", cpu_rdata, 8'h4E);
    wait_idle();
    check("R5", cpu_rdata, 8'h44);

    // R6: improper start keeps flash select
    cpu_write(8'h80);
    cpu_write(8'h82);
    check("R6", cpu_rdata, 8'h88);
    check("R6", {7'b0, op_start}, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule